// File: doc/BRIEF.md
# Single-Wire Slave Bit-Timing Engine

This block is the physical front end of a slave device on one open-drain data line that idles high. It watches the line through a synchronizer clocked by the system clock. It recognises reset pulses from the bus master and answers each one with a presence pulse. It turns every master-started time slot into either a received bit or a request for a bit to send. When the bit to send is 0, it pulls the line low for a fixed hold time after the slot's falling edge. When the bit is 1, it leaves the line alone. The only output toward the wire is an active-low pull-down enable, so the block can pull the line low but never drives it high.

The engine has two speed grades: regular and overdrive. The command layer above it requests overdrive with a one-cycle pulse on `od_set`. The engine itself leaves overdrive when the master sends a reset long enough to return every device to regular speed. A shorter reset sent in overdrive keeps overdrive active. All timings are given in microseconds as parameters and turned into clock cycles from `CLK_HZ`.

The engine is built around one state machine:

- **IDLE:** waits for a falling edge.
- **WSAMP:** waits for the write sampling point.
- **RDRV:** times the read-slot hold.
- **SLOTEND:** waits for the line to return high. It escalates to RSTLOW if the low lasts long enough to be a reset.
- **RSTLOW:** waits for the master to release the reset.
- **PRESWAIT:** the gap before the presence pulse.
- **PRESDRV:** drives the presence pulse.
- **PRESEND:** waits for the line to read high again.

The transitions are as follows:

| From | To | When |
|------|----|------|
| IDLE | WSAMP | Fall seen with receive mode selected |
| IDLE | RDRV | Fall seen with transmit mode selected |
| WSAMP | SLOTEND | Sample point reached |
| RDRV | SLOTEND | Hold time reached |
| SLOTEND | IDLE | Line reads high |
| SLOTEND | RSTLOW | Reset threshold reached |
| RSTLOW | PRESWAIT | Release seen |
| PRESWAIT | PRESDRV | Gap elapsed |
| PRESDRV | PRESEND | Pulse length elapsed |
| PRESEND | IDLE | Line reads high |

Top module: `sl_slave_phy`

## Requirements
- R1: While `rst_n` is low and right after it is released, `line_drv_n` is 1, `od_active` is 0, and `rx_valid`, `tx_req` and `bus_reset` are 0.
- R2: With `tx_mode` = 0, each falling edge of the line yields exactly one one-cycle `rx_valid` pulse. `rx_bit` is the line level 30 µs after the edge (3 µs in overdrive): 1 for high, 0 for low. This includes the falling edge that later turns out to be a reset.
- R3: With `tx_mode` = 1, each falling edge yields exactly one one-cycle `tx_req` pulse and no `rx_valid`. `tx_bit` is taken in that cycle. A taken 0 pulls the line low for 30 µs (3 µs in overdrive), which keeps it low past the master's sampling point at 13 µs (2 µs in overdrive). A taken 1 leaves the line undriven.
- R4: A low lasting at least 480 µs (48 µs in overdrive) is a reset. Its release gives one one-cycle `bus_reset` pulse. A 100 µs low at regular speed gives no `bus_reset`.
- R5: After a reset is released, the presence pulse starts 15–60 µs later (2–6 µs in overdrive, nominal 30 / 3 µs). It lasts 60–240 µs (8–24 µs in overdrive, nominal 120 / 12 µs). The speed used is the one in force after that reset.
- R6: A pulse on `od_set` makes `od_active` 1 from the next cycle. A reset whose low lasted at least 480 µs clears `od_active`. A reset in overdrive that was shorter (for example 60 µs or 200 µs) leaves it at 1.
- R7: If `od_set` is high in the same cycle that the release of a reset of 480 µs or more takes effect, `od_active` ends up 0.
- R8: The line is pulled low only during a presence pulse or a read slot carrying a 0. It is never pulled low in receive-mode slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Asynchronous level of the data line |
| line_drv_n | output | 1 | Pull-down enable, active low (0 pulls the line low) |
| tx_mode | input | 1 | 1: the following slots are read slots (slave transmits) |
| tx_bit | input | 1 | Bit to send, taken in the `tx_req` cycle |
| tx_req | output | 1 | One-cycle strobe: a read slot started and `tx_bit` was taken |
| rx_valid | output | 1 | One-cycle strobe: `rx_bit` holds a new received bit |
| rx_bit | output | 1 | Last received bit |
| od_set | input | 1 | One-cycle request to enter overdrive |
| od_active | output | 1 | 1 while overdrive timing is in force |
| bus_reset | output | 1 | One-cycle strobe when a reset pulse is released |

## Verification
Entering overdrive and leaving it can land in the same cycle. This happens when the command layer pulses `od_set` exactly as the engine acts on the release of a long reset. The bench provokes the collision by raising `od_set` for the one cycle that starts on the second clock edge after the line is released, which is the cycle in which the synchronized rising edge is decoded. It judges the outcome by `od_active` reading 0 once the presence pulse is over, so the reset has won.

// File: rtl/sl_pkg.sv
package sl_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WSAMP,
        S_RDRV,
        S_SLOTEND,
        S_RSTLOW,
        S_PRESWAIT,
        S_PRESDRV,
        S_PRESEND
    } sl_state_e;

    // microseconds to system clock cycles
    function automatic int unsigned us2cyc(input int unsigned clk_hz, input int unsigned us);
        return (clk_hz / 1000000) * us;
    endfunction

endpackage

// File: rtl/sl_sync_edge.sv
module sl_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic lvl,
    output logic fall,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // the idle level of the line is high, so every stage resets to 1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], line_in};
            prev  <= chain[STAGES-1];
        end
    end

    assign lvl  = chain[STAGES-1];
    assign fall = prev & ~lvl;
    assign rise = ~prev & lvl;
endmodule

// File: rtl/sl_tick_timer.sv
module sl_tick_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [TW-1:0] cnt
);
    // saturating count of cycles since the last clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sl_speed_sel.sv
module sl_speed_sel #(
    parameter int          TW      = 16,
    parameter int unsigned P_SAMP  = 30,
    parameter int unsigned O_SAMP  = 3,
    parameter int unsigned P_HOLD  = 30,
    parameter int unsigned O_HOLD  = 3,
    parameter int unsigned P_RST   = 480,
    parameter int unsigned O_RST   = 48,
    parameter int unsigned P_PWAIT = 30,
    parameter int unsigned O_PWAIT = 3,
    parameter int unsigned P_PLEN  = 120,
    parameter int unsigned O_PLEN  = 12
) (
    input  logic          od,
    output logic [TW-1:0] samp_c,
    output logic [TW-1:0] hold_c,
    output logic [TW-1:0] rst_c,
    output logic [TW-1:0] pwait_c,
    output logic [TW-1:0] plen_c
);
    assign samp_c  = od ? TW'(O_SAMP)  : TW'(P_SAMP);
    assign hold_c  = od ? TW'(O_HOLD)  : TW'(P_HOLD);
    assign rst_c   = od ? TW'(O_RST)   : TW'(P_RST);
    assign pwait_c = od ? TW'(O_PWAIT) : TW'(P_PWAIT);
    assign plen_c  = od ? TW'(O_PLEN)  : TW'(P_PLEN);
endmodule

// File: rtl/sl_slave_phy.sv
module sl_slave_phy
    import sl_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 125_000_000,
    parameter int          SYNC_STAGES = 2,
    parameter int unsigned RST_US      = 480,
    parameter int unsigned OD_RST_US   = 48,
    parameter int unsigned EXIT_OD_US  = 480,
    parameter int unsigned SAMP_US     = 30,
    parameter int unsigned OD_SAMP_US  = 3,
    parameter int unsigned HOLD_US     = 30,
    parameter int unsigned OD_HOLD_US  = 3,
    parameter int unsigned PWAIT_US    = 30,
    parameter int unsigned OD_PWAIT_US = 3,
    parameter int unsigned PLEN_US     = 120,
    parameter int unsigned OD_PLEN_US  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_drv_n,
    input  logic tx_mode,
    input  logic tx_bit,
    output logic tx_req,
    output logic rx_valid,
    output logic rx_bit,
    input  logic od_set,
    output logic od_active,
    output logic bus_reset
);
    localparam int unsigned RST_C  = us2cyc(CLK_HZ, RST_US);
    localparam int unsigned EXIT_C = us2cyc(CLK_HZ, EXIT_OD_US);
    localparam int unsigned PLEN_C = us2cyc(CLK_HZ, PLEN_US);
    localparam int unsigned MAX_A  = (RST_C > EXIT_C) ? RST_C : EXIT_C;
    localparam int unsigned MAXC   = (PLEN_C > MAX_A) ? PLEN_C : MAX_A;
    localparam int          TW     = $clog2(MAXC + 2);
    localparam logic [TW-1:0] EXIT_T = TW'(EXIT_C);

    sl_state_e     st, nx;
    logic          lvl, fall, rise;
    logic          tmr_clr;
    logic [TW-1:0] tmr;
    logic [TW-1:0] samp_c, hold_c, rst_c, pwait_c, plen_c;
    logic          od_q, txb_q;
    logic          take_rx, take_tx, rst_evt, od_drop;
    logic          drive0, pull_nx;

    sl_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .lvl     (lvl),
        .fall    (fall),
        .rise    (rise)
    );

    sl_tick_timer #(.TW(TW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .cnt   (tmr)
    );

    sl_speed_sel #(
        .TW      (TW),
        .P_SAMP  (us2cyc(CLK_HZ, SAMP_US)),
        .O_SAMP  (us2cyc(CLK_HZ, OD_SAMP_US)),
        .P_HOLD  (us2cyc(CLK_HZ, HOLD_US)),
        .O_HOLD  (us2cyc(CLK_HZ, OD_HOLD_US)),
        .P_RST   (RST_C),
        .O_RST   (us2cyc(CLK_HZ, OD_RST_US)),
        .P_PWAIT (us2cyc(CLK_HZ, PWAIT_US)),
        .O_PWAIT (us2cyc(CLK_HZ, OD_PWAIT_US)),
        .P_PLEN  (PLEN_C),
        .O_PLEN  (us2cyc(CLK_HZ, OD_PLEN_US))
    ) u_speed (
        .od      (od_q),
        .samp_c  (samp_c),
        .hold_c  (hold_c),
        .rst_c   (rst_c),
        .pwait_c (pwait_c),
        .plen_c  (plen_c)
    );

    // next-state and event decode
    always_comb begin
        nx      = st;
        tmr_clr = 1'b0;
        take_rx = 1'b0;
        take_tx = 1'b0;
        rst_evt = 1'b0;
        od_drop = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (fall) begin
                    tmr_clr = 1'b1;
                    if (tx_mode) begin
                        nx      = S_RDRV;
                        take_tx = 1'b1;
                    end else begin
                        nx = S_WSAMP;
                    end
                end
            end
            S_WSAMP: begin
                if (tmr >= samp_c) begin
                    nx      = S_SLOTEND;
                    take_rx = 1'b1;
                end
            end
            S_RDRV: begin
                if (tmr >= hold_c) nx = S_SLOTEND;
            end
            S_SLOTEND: begin
                if (lvl)                 nx = S_IDLE;
                else if (tmr >= rst_c)   nx = S_RSTLOW;
            end
            S_RSTLOW: begin
                if (rise) begin
                    nx      = S_PRESWAIT;
                    tmr_clr = 1'b1;
                    rst_evt = 1'b1;
                    od_drop = (tmr >= EXIT_T);
                end
            end
            S_PRESWAIT: begin
                if (tmr >= pwait_c) begin
                    nx      = S_PRESDRV;
                    tmr_clr = 1'b1;
                end
            end
            S_PRESDRV: begin
                if (tmr >= plen_c) nx = S_PRESEND;
            end
            S_PRESEND: begin
                if (lvl) nx = S_IDLE;
            end
        endcase
    end

    // the bit for a read slot comes straight from the port in the start cycle
    assign drive0  = (st == S_IDLE) ? ~tx_bit : ~txb_q;
    assign pull_nx = (nx == S_PRESDRV) || ((nx == S_RDRV) && drive0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nx;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_drv_n <= 1'b1;
            rx_valid   <= 1'b0;
            rx_bit     <= 1'b0;
            tx_req     <= 1'b0;
            txb_q      <= 1'b1;
            bus_reset  <= 1'b0;
            od_q       <= 1'b0;
        end else begin
            line_drv_n <= ~pull_nx;
            rx_valid   <= take_rx;
            if (take_rx) rx_bit <= lvl;
            tx_req     <= take_tx;
            if (take_tx) txb_q <= tx_bit;
            bus_reset  <= rst_evt;
            // a long reset outranks a coincident overdrive request
            if (od_drop)     od_q <= 1'b0;
            else if (od_set) od_q <= 1'b1;
        end
    end

    assign od_active = od_q;
endmodule

// File: rtl/sl_slave_phy_chk.sv
module sl_slave_phy_chk
    import sl_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input sl_state_e st,
    input logic      line_drv_n,
    input logic      tx_mode,
    input logic      tx_req,
    input logic      rx_valid,
    input logic      bus_reset,
    input logic      od_set,
    input logic      od_active
);
    p_rx_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_txreq_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> $past(tx_mode));

    p_rst_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !bus_reset);

    p_pres_after_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PRESWAIT && $past(st) != S_PRESWAIT) |-> bus_reset);

    p_od_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(od_active) |-> bus_reset);

    p_od_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(od_active) |-> $past(od_set));

    p_drive_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_drv_n) |-> (tx_req || st == S_PRESDRV));
endmodule

bind sl_slave_phy sl_slave_phy_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (st),
    .line_drv_n (line_drv_n),
    .tx_mode    (tx_mode),
    .tx_req     (tx_req),
    .rx_valid   (rx_valid),
    .bus_reset  (bus_reset),
    .od_set     (od_set),
    .od_active  (od_active)
);

// File: tb/sim_sl_slave_phy.sv
module sim_sl_slave_phy;
    localparam int CPU = 4;            // cycles per microsecond in the bench

    logic clk = 1'b0;
    always #4 clk = ~clk;              // 125 MHz

    logic rst_n = 1'b0;
    logic m_low = 1'b0;
    logic od_set = 1'b0, tx_mode = 1'b0, tx_bit = 1'b1;
    logic line_drv_n, tx_req, rx_valid, rx_bit, od_active, bus_reset;
    logic line;
    assign line = ~(m_low | ~line_drv_n);

    sl_slave_phy #(.CLK_HZ(4_000_000)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (line),
        .line_drv_n (line_drv_n),
        .tx_mode    (tx_mode),
        .tx_bit     (tx_bit),
        .tx_req     (tx_req),
        .rx_valid   (rx_valid),
        .rx_bit     (rx_bit),
        .od_set     (od_set),
        .od_active  (od_active),
        .bus_reset  (bus_reset)
    );

    int   checks = 0, errors = 0;
    int   rx_cnt = 0, txr_cnt = 0, brst_cnt = 0, drv_cnt = 0;
    logic rx_last = 1'b0;
    logic bod = 1'b0;
    bit   done = 1'b0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin rx_cnt++; rx_last = rx_bit; end
            if (tx_req) txr_cnt++;
            if (bus_reset) brst_cnt++;
            if (!line_drv_n) drv_cnt++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_us(input int n);
        repeat (n * CPU) @(negedge clk);
    endtask

    task automatic bus_rst(input int low_us, output int dly, output int len);
        m_low = 1'b1;
        wait_us(low_us);
        m_low = 1'b0;
        dly = 0;
        while (line_drv_n && dly < 400 * CPU) begin @(negedge clk); dly++; end
        len = 0;
        while (!line_drv_n && len < 400 * CPU) begin @(negedge clk); len++; end
        wait_us(10);
    endtask

    task automatic chk_pres(input bit od, input int dly, input int len, input string tag);
        int dlo = od ? 2 : 15,  dhi = od ? 6 : 60;
        int llo = od ? 8 : 60,  lhi = od ? 24 : 240;
        chk(dly >= dlo * CPU && dly <= dhi * CPU, {tag, " R5 presence delay"}, dly, (dlo + dhi) * CPU / 2);
        chk(len >= llo * CPU && len <= lhi * CPU, {tag, " R5 presence length"}, len, (llo + lhi) * CPU / 2);
    endtask

    task automatic wr_slot(input bit b, input string tag);
        int r0 = rx_cnt, d0 = drv_cnt;
        int lo = bod ? (b ? 1 : 8) : (b ? 5 : 70);
        int sl = bod ? 14 : 90;
        m_low = 1'b1;
        wait_us(lo);
        m_low = 1'b0;
        wait_us(sl - lo);
        chk(rx_cnt == r0 + 1, {tag, " R2 one rx strobe"}, rx_cnt - r0, 1);
        chk(rx_last == b, {tag, " R2 rx bit"}, int'(rx_last), int'(b));
        chk(drv_cnt == d0, {tag, " R8 no drive in write slot"}, drv_cnt - d0, 0);
    endtask

    task automatic rd_slot(input bit b, input string tag);
        int t0, r0;
        logic smp;
        tx_bit = b;
        @(negedge clk);
        t0 = txr_cnt; r0 = rx_cnt;
        m_low = 1'b1;
        wait_us(bod ? 1 : 2);
        m_low = 1'b0;
        wait_us(bod ? 1 : 11);
        smp = line;
        wait_us(bod ? 12 : 77);
        chk(smp == b, {tag, " R3 line at master sample"}, int'(smp), int'(b));
        chk(txr_cnt == t0 + 1, {tag, " R3 one tx request"}, txr_cnt - t0, 1);
        chk(rx_cnt == r0, {tag, " R3 no rx strobe"}, rx_cnt - r0, 0);
    endtask

    task automatic od_pulse();
        @(negedge clk) od_set = 1'b1;
        @(negedge clk) od_set = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk(line_drv_n == 1'b1, "R1 line released in reset", int'(line_drv_n), 1);
        chk(od_active == 1'b0, "R1 regular speed in reset", int'(od_active), 0);
        chk({rx_valid, tx_req, bus_reset} == 3'b000, "R1 strobes idle in reset",
            int'({rx_valid, tx_req, bus_reset}), 0);
        rst_n = 1'b1;
        wait_us(5);
        chk(line_drv_n == 1'b1 && brst_cnt == 0 && rx_cnt == 0 && txr_cnt == 0,
            "R1 quiet after reset release", drv_cnt + brst_cnt + rx_cnt, 0);
    endtask

    task automatic t_reset_reg();
        int d, l, b0 = brst_cnt;
        bus_rst(500, d, l);
        chk(brst_cnt == b0 + 1, "R4 regular reset strobe", brst_cnt - b0, 1);
        chk_pres(1'b0, d, l, "regular");
    endtask

    task automatic t_write_reg();
        logic [7:0] pat = 8'hA5;
        for (int i = 0; i < 8; i++) wr_slot(pat[i], "regular write");
    endtask

    task automatic t_short_low();
        int b0 = brst_cnt;
        m_low = 1'b1;
        wait_us(100);
        m_low = 1'b0;
        wait_us(20);
        chk(brst_cnt == b0, "R4 100us low is no reset", brst_cnt - b0, 0);
        chk(rx_last == 1'b0, "R2 long low reads as 0", int'(rx_last), 0);
    endtask

    task automatic t_read(input string tag);
        tx_mode = 1'b1;
        rd_slot(1'b0, tag);
        rd_slot(1'b1, tag);
        rd_slot(1'b1, tag);
        rd_slot(1'b0, tag);
        tx_mode = 1'b0;
        tx_bit  = 1'b1;
        wait_us(5);
    endtask

    task automatic t_od_enter();
        od_pulse();
        chk(od_active == 1'b1, "R6 od_set enters overdrive", int'(od_active), 1);
        bod = 1'b1;
    endtask

    task automatic t_write_od();
        logic [3:0] pat = 4'b0110;
        for (int i = 0; i < 4; i++) wr_slot(pat[i], "overdrive write");
    endtask

    task automatic t_od_rst(input int low_us, input bit keep, input string tag);
        int d, l, b0 = brst_cnt;
        bus_rst(low_us, d, l);
        chk(brst_cnt == b0 + 1, {tag, " R4 reset strobe"}, brst_cnt - b0, 1);
        chk(od_active == keep, {tag, " R6 speed after reset"}, int'(od_active), int'(keep));
        chk_pres(keep, d, l, tag);
        bod = keep;
    endtask

    task automatic t_collide();
        od_pulse();
        m_low = 1'b1;
        wait_us(500);
        m_low = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk) od_set = 1'b1;
        @(negedge clk) od_set = 1'b0;
        wait_us(200);
        chk(od_active == 1'b0, "R7 long reset beats od_set", int'(od_active), 0);
        bod = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset_state();
        t_reset_reg();
        t_write_reg();
        t_short_low();
        t_read("regular read");
        t_od_enter();
        t_write_od();
        t_read("overdrive read");
        t_od_rst(60, 1'b1, "od short reset");
        t_od_rst(200, 1'b1, "od mid reset");
        t_od_rst(500, 1'b0, "od long reset");
        t_collide();
        wr_slot(1'b1, "after collision");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule